// File: doc/BRIEF.md
# SDRAM Clock-Enable Low-Power Sequencer

This block sits on the controller side of an SDRAM interface and owns the clock-enable pin. A client asks for a low-power phase with one of two level requests. A suspend request made while a burst is running pulls clock enable low, which freezes the device's internal clock and keeps its state. A power-down request made while every bank is idle and no burst runs pulls clock enable low as power-down entry. The matching acknowledge stays high for as long as the pin is held low for that reason.

Neither low phase refreshes the array, so a watchdog counts the cycles spent low. A few cycles before the refresh interval would run out, it forces an exit and raises refresh-urgent. After any exit the block keeps command issue blocked. A suspend exit blocks it for a single gap cycle. A power-down exit first waits out the exit time and then adds the gap cycle. After a forced exit, no new low-power request is taken until the client has dropped both requests.

Top module: `cke_pd_sequencer`

## Requirements
- R1: After synchronous reset, clock enable is 1, command-allowed is 1, and both acknowledges and refresh-urgent are 0.
- R2: From the running state, with refresh-urgent low, suspend request high and burst-active high at an edge, clock enable goes to 0 and the suspend acknowledge goes to 1 after that edge. Command-allowed is 0 while suspended.
- R3: From the running state, with refresh-urgent low, power-down request high, bank-idle high and burst-active low at an edge, clock enable goes to 0 and the power-down acknowledge goes to 1 after that edge.
- R4: A power-down request is ignored while bank-idle is low or burst-active is high. A suspend request is ignored while burst-active is low. Clock enable stays 1 and both acknowledges stay 0.
- R5: When both requests qualify in the same cycle, suspend wins.
- R6: Dropping the suspend request raises clock enable at the next edge. Command-allowed is then 0 for exactly one cycle and returns to 1.
- R7: Dropping the power-down request raises clock enable at the next edge. Command-allowed is then 0 for exactly PDE_CYCLES + 1 cycles.
- R8: Clock enable is never low for more than REFRESH_CYCLES − URGENT_MARGIN consecutive cycles, where REFRESH_CYCLES = CLK_KHZ × REFRESH_MS. When that count is reached, the block exits even if the request is still held.
- R9: Refresh-urgent rises together with clock enable on a forced exit. It stays high until the block is running and both requests were low at an edge.
- R10: While refresh-urgent is high, no request is accepted and clock enable stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| suspReq | input | 1 | Level request for clock suspend |
| pdReq | input | 1 | Level request for power-down |
| banksIdle | input | 1 | All banks are precharged |
| burstActive | input | 1 | A read or write burst is in progress |
| suspAck | output | 1 | Device is clock-suspended |
| pdAck | output | 1 | Device is powered down |
| cke | output | 1 | Clock enable pin drive |
| cmdAllowed | output | 1 | A new SDRAM command may be issued |
| refreshUrgent | output | 1 | A forced exit happened; refresh is due |

## Verification
Every output comes straight from a state register. A qualified request therefore shows on clock enable and its acknowledge one edge after the request is sampled. Dropping a request shows on clock enable one edge later. Command-allowed recovers one edge after the suspend exit, or PDE_CYCLES + 1 edges after the power-down exit. The watchdog exit lands on the edge that ends the last permitted low cycle.

The bench drives inputs on the falling edge and compares outputs on the next falling edge. It uses a cycle model that steps on the same edge. Exit gaps and the length of the low run are measured by counting falling-edge samples from the release.

// File: rtl/ckeseq_pkg.sv
package ckeseq_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_SUSPEND   = 3'd1,
    ST_POWERDOWN = 3'd2,
    ST_EXIT_WAIT = 3'd3,
    ST_GAP       = 3'd4
  } seqState_t;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic lowRun;     // clock enable is low this cycle
    logic waitRun;    // waiting out the power-down exit time
    logic setUrgent;  // watchdog forced an exit
    logic clrUrgent;  // client released both requests while running
  } seqStrobe_t;

endpackage

// File: rtl/ckeseq_timer.sv
module ckeseq_timer
  import ckeseq_pkg::*;
#(
  parameter int LOW_MAX    = 1000,
  parameter int PDE_CYCLES = 2,
  localparam int LOW_W     = $clog2(LOW_MAX + 1),
  localparam int WAIT_W    = $clog2(PDE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strobe,
  output logic       lowExpired,
  output logic       waitDone,
  output logic       urgent
);

  logic [LOW_W-1:0]  lowCnt;
  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (rst || !strobe.lowRun) lowCnt <= '0;
    else                       lowCnt <= lowCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !strobe.waitRun) waitCnt <= '0;
    else                        waitCnt <= waitCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                   urgent <= 1'b0;
    else if (strobe.setUrgent) urgent <= 1'b1;
    else if (strobe.clrUrgent) urgent <= 1'b0;
  end

  assign lowExpired = strobe.lowRun  && (lowCnt  == LOW_W'(LOW_MAX - 1));
  assign waitDone   = strobe.waitRun && (waitCnt == WAIT_W'(PDE_CYCLES - 1));

  // R9: a forced exit always leaves the urgent flag set on the next cycle
  assert_urgent_sets_R9: assert property (@(posedge clk) disable iff (rst)
    strobe.setUrgent |=> urgent);

endmodule

// File: rtl/ckeseq_ctrl.sv
module ckeseq_ctrl
  import ckeseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       suspReq,
  input  logic       pdReq,
  input  logic       banksIdle,
  input  logic       burstActive,
  input  logic       lowExpired,
  input  logic       waitDone,
  input  logic       urgent,
  output seqStrobe_t strobe,
  output logic       suspAck,
  output logic       pdAck,
  output logic       cke,
  output logic       cmdAllowed
);

  seqState_t state, nextState;
  logic      forceExit;

  always_comb begin
    nextState = state;
    forceExit = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (!urgent && suspReq && burstActive)
          nextState = ST_SUSPEND;
        else if (!urgent && pdReq && banksIdle && !burstActive)
          nextState = ST_POWERDOWN;
      end
      ST_SUSPEND: begin
        if (lowExpired) begin
          nextState = ST_GAP;
          forceExit = 1'b1;
        end else if (!suspReq) begin
          nextState = ST_GAP;
        end
      end
      ST_POWERDOWN: begin
        if (lowExpired) begin
          nextState = ST_EXIT_WAIT;
          forceExit = 1'b1;
        end else if (!pdReq) begin
          nextState = ST_EXIT_WAIT;
        end
      end
      ST_EXIT_WAIT: if (waitDone) nextState = ST_GAP;
      ST_GAP:       nextState = ST_RUN;
      default:      nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RUN;
    else     state <= nextState;
  end

  always_comb begin
    strobe.lowRun    = (state == ST_SUSPEND) || (state == ST_POWERDOWN);
    strobe.waitRun   = (state == ST_EXIT_WAIT);
    strobe.setUrgent = forceExit;
    strobe.clrUrgent = (state == ST_RUN) && !suspReq && !pdReq;
  end

  assign suspAck    = (state == ST_SUSPEND);
  assign pdAck      = (state == ST_POWERDOWN);
  assign cke        = !strobe.lowRun;
  assign cmdAllowed = (state == ST_RUN);

  // R2: a qualified suspend request is taken at the next edge
  assert_susp_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (cmdAllowed && !urgent && suspReq && burstActive) |=> (suspAck && !cke));

  // R4: power-down is never taken with a bank open
  assert_pd_busy_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (cmdAllowed && pdReq && !banksIdle && !(suspReq && burstActive)) |=> !pdAck);

  // R6: a suspend exit leaves exactly one blocked cycle
  assert_susp_gap_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(cke) && $past(suspAck)) |-> (!cmdAllowed ##1 cmdAllowed));

  // R7: a power-down exit blocks commands on the first high cycle
  assert_pd_exit_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(cke) && $past(pdAck)) |-> !cmdAllowed);

  // R10: urgent blocks a fresh low phase
  assert_urgent_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (cmdAllowed && urgent) |=> cke);

endmodule

// File: rtl/cke_pd_sequencer.sv
module cke_pd_sequencer
  import ckeseq_pkg::*;
#(
  parameter int CLK_KHZ       = 133000,
  parameter int REFRESH_MS    = 64,
  parameter int URGENT_MARGIN = 4096,
  parameter int PDE_CYCLES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic suspReq,
  input  logic pdReq,
  input  logic banksIdle,
  input  logic burstActive,
  output logic suspAck,
  output logic pdAck,
  output logic cke,
  output logic cmdAllowed,
  output logic refreshUrgent
);

  localparam int REFRESH_CYCLES = CLK_KHZ * REFRESH_MS;
  localparam int LOW_MAX        = REFRESH_CYCLES - URGENT_MARGIN;
  localparam int RUN_W          = $clog2(REFRESH_CYCLES + 1);

  seqStrobe_t strobe;
  logic       lowExpired, waitDone, urgent;

  ckeseq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .suspReq    (suspReq),
    .pdReq      (pdReq),
    .banksIdle  (banksIdle),
    .burstActive(burstActive),
    .lowExpired (lowExpired),
    .waitDone   (waitDone),
    .urgent     (urgent),
    .strobe     (strobe),
    .suspAck    (suspAck),
    .pdAck      (pdAck),
    .cke        (cke),
    .cmdAllowed (cmdAllowed)
  );

  ckeseq_timer #(
    .LOW_MAX   (LOW_MAX),
    .PDE_CYCLES(PDE_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .lowExpired(lowExpired),
    .waitDone  (waitDone),
    .urgent    (urgent)
  );

  assign refreshUrgent = urgent;

  // independent count of consecutive low cycles on the pin
  logic [RUN_W-1:0] ckeLowRun;
  always_ff @(posedge clk) begin
    if (rst || cke)                                    ckeLowRun <= '0;
    else if (ckeLowRun != RUN_W'(REFRESH_CYCLES))      ckeLowRun <= ckeLowRun + 1'b1;
  end

  // R8: never low beyond the watchdog limit, and so never past the refresh interval
  assert_cke_limit_R8: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (ckeLowRun < RUN_W'(LOW_MAX)));

endmodule

// File: tb/tb_cke_pd_sequencer.sv
module tb_cke_pd_sequencer;

  localparam int CLK_KHZ = 1, REFRESH_MS = 50, MARGIN = 6, PDE = 3;
  localparam int LOW_MAX = CLK_KHZ * REFRESH_MS - MARGIN;
  localparam int M_RUN = 0, M_SUS = 1, M_PD = 2, M_EXIT = 3, M_GAP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic suspReq = 0, pdReq = 0, banksIdle = 0, burstActive = 0;
  logic suspAck, pdAck, cke, cmdAllowed, refreshUrgent;

  int total = 0, bad = 0;
  int mSt = M_RUN, mLow = 0, mWait = 0;
  bit mUrg = 0;
  string curTag = "";

  always #2 clk = ~clk;

  cke_pd_sequencer #(.CLK_KHZ(CLK_KHZ), .REFRESH_MS(REFRESH_MS),
                     .URGENT_MARGIN(MARGIN), .PDE_CYCLES(PDE)) dut (
    .clk(clk), .rst(rst), .suspReq(suspReq), .pdReq(pdReq),
    .banksIdle(banksIdle), .burstActive(burstActive), .suspAck(suspAck),
    .pdAck(pdAck), .cke(cke), .cmdAllowed(cmdAllowed), .refreshUrgent(refreshUrgent));

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string pick(string dflt);
    return (curTag == "") ? dflt : curTag;
  endfunction

  task automatic compareAll();
    bit eLow;
    eLow = (mSt == M_SUS) || (mSt == M_PD);
    chk(cke === !eLow, pick("R8"), "cke", cke, !eLow);
    chk(cmdAllowed === (mSt == M_RUN), pick("R7"), "cmdAllowed", cmdAllowed, mSt == M_RUN);
    chk(suspAck === (mSt == M_SUS), pick("R2"), "suspAck", suspAck, mSt == M_SUS);
    chk(pdAck === (mSt == M_PD), pick("R3"), "pdAck", pdAck, mSt == M_PD);
    chk(refreshUrgent === mUrg, pick("R9"), "refreshUrgent", refreshUrgent, mUrg);
  endtask

  // reference model: state after the coming edge, given the inputs held across it
  task automatic stepModel(bit s, bit p, bit bi, bit ba);
    int nSt;
    bit nUrg;
    bit exp_;
    nSt = mSt; nUrg = mUrg;
    exp_ = (mLow == LOW_MAX - 1);
    case (mSt)
      M_RUN: begin
        if (!mUrg && s && ba) nSt = M_SUS;
        else if (!mUrg && p && bi && !ba) nSt = M_PD;
        if (!s && !p) nUrg = 0;
      end
      M_SUS: if (exp_) begin nSt = M_GAP; nUrg = 1; end else if (!s) nSt = M_GAP;
      M_PD:  if (exp_) begin nSt = M_EXIT; nUrg = 1; end else if (!p) nSt = M_EXIT;
      M_EXIT: if (mWait == PDE - 1) nSt = M_GAP;
      default: nSt = M_RUN;
    endcase
    mLow  = (mSt == M_SUS || mSt == M_PD) ? mLow + 1 : 0;
    mWait = (mSt == M_EXIT) ? mWait + 1 : 0;
    mSt = nSt; mUrg = nUrg;
  endtask

  task automatic step(bit s, bit p, bit bi, bit ba);
    @(negedge clk);
    compareAll();
    suspReq = s; pdReq = p; banksIdle = bi; burstActive = ba;
    stepModel(s, p, bi, ba);
  endtask

  // count blocked samples after a release already applied
  task automatic countBlocked(output int n);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      step(0, 0, 1, 0);
      if (cmdAllowed) break;
      n++;
    end
  endtask

  initial begin
    int n, lowRun;
    bit s, p, bi, ba;
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    stepModel(0, 0, 0, 0);

    // R1 reset state
    @(negedge clk);
    chk(cke && cmdAllowed && !suspAck && !pdAck && !refreshUrgent, "R1", "reset outputs",
        {cke, cmdAllowed, suspAck, pdAck, refreshUrgent}, 5'b11000);

    // R4 requests that do not qualify
    curTag = "R4";
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 1, 1);
    for (int i = 0; i < 4; i++) step(1, 0, 1, 0);
    step(0, 0, 1, 0);
    chk(cke && !pdAck && !suspAck, "R4", "ignored request kept cke high", cke, 1);

    // R5 both qualify: suspend wins
    curTag = "R5";
    step(1, 1, 1, 1);
    step(1, 1, 1, 1);
    chk(suspAck && !pdAck, "R5", "suspAck over pdAck", {suspAck, pdAck}, 2'b10);

    // R6 suspend exit gap
    curTag = "R6";
    step(1, 0, 0, 1);
    step(0, 0, 1, 0);
    countBlocked(n);
    chk(n == 1, "R6", "blocked cycles after suspend exit", n, 1);

    // R3 / R7 power-down entry and exit time
    curTag = "R3";
    step(0, 1, 1, 0);
    step(0, 1, 1, 0);
    chk(pdAck && !cke, "R3", "power-down entered", pdAck, 1);
    curTag = "R7";
    step(0, 0, 1, 0);
    countBlocked(n);
    chk(n == PDE + 1, "R7", "blocked cycles after power-down exit", n, PDE + 1);

    // R8 / R9 / R10 watchdog forced exit with request held
    curTag = "R8";
    lowRun = 0; n = 0;
    for (int i = 0; i < LOW_MAX + 20; i++) begin
      step(0, 1, 1, 0);
      if (!cke) lowRun++;
    end
    chk(lowRun == LOW_MAX, "R8", "cke low cycles under held request", lowRun, LOW_MAX);
    chk(refreshUrgent === 1'b1, "R9", "urgent after forced exit", refreshUrgent, 1);
    chk(cke && cmdAllowed, "R10", "held request not re-accepted", {cke, cmdAllowed}, 2'b11);
    curTag = "R9";
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    chk(refreshUrgent === 1'b0, "R9", "urgent cleared after release", refreshUrgent, 0);

    // random phase
    curTag = "";
    s = 0; p = 0; bi = 1; ba = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) s = !s;
      if ($urandom_range(0, 19) == 0) p = !p;
      if ($urandom_range(0, 7) == 0)  bi = !bi;
      if ($urandom_range(0, 7) == 0)  ba = !ba;
      step(s, p, bi, ba);
    end
    step(0, 0, 1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule